// File: doc/BRIEF.md
# Output Compare Unit with Split-Write Inhibit

This block holds a 16-bit compare value and checks it against a free-running count that comes in from outside. A CPU with an 8-bit bus loads the value one byte at a time. When the count reaches the value, the unit raises a compare flag. It also copies a level bit that software chose earlier into a latch that drives an output pin. An interrupt request follows the flag whenever the interrupt is enabled.

Software writes the value high byte first. A high-byte write holds off all comparison until the low byte is written, so a value that is only half updated can never give a false match. A write to the low byte alone leaves comparison running. Software can therefore move the value within the same 256-count page without stopping the compare. The flag clears only through a two-step sequence: a status read that sees the flag set, then a low-byte write.

Top module: `ocmp_unit`

## Requirements
- R1: The compare value is readable and writable over the bus: high byte at address 0x16, low byte at 0x17.
- R2: Reset clears the control bits, the flag, the inhibit state and the pin latch to 0, and leaves both compare bytes unchanged.
- R3: Comparison is active when no write inhibit is pending. In the first cycle in which the count equals the compare value, the flag sets at the next clock edge. The flag reads as bit 6 of the status register at 0x13. A count that stays equal raises only one event.
- R4: A write to 0x16 stops comparison until the next write to 0x17. A count equal to the compare value during that gap sets no flag. If the count equals the value when 0x17 is written, the flag sets once the inhibit lifts.
- R5: A write to 0x17 with no earlier pending 0x16 write does not stop comparison.
- R6: On a compare event, the pin latch takes the level bit, which is bit 0 of the control register at 0x12. At other times the pin latch holds its value.
- R7: The interrupt output is high exactly when the interrupt enable (control bit 6) and the flag are both set.
- R8: The flag clears on a write to 0x17 that follows a status read which saw the flag set. A write to 0x17 with no such read leaves the flag set.
- R9: The control register at 0x12 stores bits 6 and 0. Its other bits read as 0, and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| count | input | 16 | Free-running count from the timer |
| cmp_pin | output | 1 | Output level latch that drives the pin |
| irq | output | 1 | Compare interrupt request |

## Verification
The hardest case to reach is a count that already equals the new compare value while a high-byte write is still waiting for its low byte. The flag must stay clear during that gap and must set as soon as the low byte lands. The bench holds the count on the full new value, writes only the high byte, checks the flag, and then writes the low byte and checks again. A second hard case is clearing the flag while the count is still equal to the value. The bench shows that no new event follows, because the equality did not newly begin.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
    localparam int BUS_W  = 8;
    localparam int CNT_W  = 16;
    localparam int NBYTES = CNT_W / BUS_W;

    localparam logic [BUS_W-1:0] ADDR_CTRL = 8'h12;
    localparam logic [BUS_W-1:0] ADDR_STAT = 8'h13;
    localparam logic [BUS_W-1:0] ADDR_CMPH = 8'h16;   // most significant byte
    localparam int LOW_IDX = 0;                      // byte index whose write re-arms

    localparam int BIT_LVL = 0;
    localparam int BIT_IE  = 6;
    localparam int BIT_FLG = 6;

    typedef struct packed {
        logic lvl;
        logic ie;
        logic inhibit;
    } ctrl_state_t;

    typedef struct packed {
        logic ocf;
        logic armed;
        logic pin;
    } flag_state_t;
endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
    import ocmp_pkg::*;
#(
    parameter int BW = BUS_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [BW-1:0] bus_wdata,
    output logic [CW-1:0] cmp_val,
    output logic          lvl,
    output logic          ie,
    output logic          inhibit,
    output logic          lo_wr
);
    localparam int NB = CW / BW;

    ctrl_state_t st_d, st_q;
    logic [NB-1:0] byte_wr;

    // compare bytes: not reset, never touched by hardware
    for (genvar i = 0; i < NB; i++) begin : g_byte
        logic [BW-1:0] b_q;
        assign byte_wr[i] = bus_wr && (bus_addr == ADDR_CMPH + BW'(NB-1-i));
        always_ff @(posedge clk) begin
            if (byte_wr[i]) b_q <= bus_wdata;
        end
        assign cmp_val[i*BW +: BW] = b_q;
    end

    assign lo_wr = byte_wr[LOW_IDX];

    always_comb begin
        st_d = st_q;
        if (bus_wr && bus_addr == ADDR_CTRL) begin
            st_d.lvl = bus_wdata[BIT_LVL];
            st_d.ie  = bus_wdata[BIT_IE];
        end
        if (|(byte_wr & ~(NB'(1) << LOW_IDX))) st_d.inhibit = 1'b1;
        if (lo_wr)                             st_d.inhibit = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl     = st_q.lvl;
    assign ie      = st_q.ie;
    assign inhibit = st_q.inhibit;

    assert_msb_inhibits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_CMPH) |=> inhibit);
    assert_lsb_rearms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> !inhibit);
endmodule

// File: rtl/ocmp_match.sv
module ocmp_match
    import ocmp_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] cmp_val,
    input  logic          inhibit,
    output logic          match_evt
);
    logic eq;
    logic hit_d, hit_q;

    always_comb begin
        eq        = (count == cmp_val) && !inhibit;
        hit_d     = eq;
        match_evt = eq && !hit_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_d;
    end

    assert_no_match_inhibited_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> !match_evt);
    assert_single_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && $stable(count)) |=> (!match_evt || count != $past(count)
                                           || cmp_val != $past(cmp_val)));
endmodule

// File: rtl/ocmp_flag.sv
module ocmp_flag
    import ocmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_evt,
    input  logic lvl,
    input  logic stat_rd,
    input  logic lo_wr,
    output logic ocf,
    output logic pin
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stat_rd && st_q.ocf) st_d.armed = 1'b1;
        if (lo_wr && st_q.armed) begin
            st_d.ocf   = 1'b0;
            st_d.armed = 1'b0;
        end
        if (match_evt) begin
            st_d.ocf = 1'b1;
            st_d.pin = lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ocf = st_q.ocf;
    assign pin = st_q.pin;

    assert_match_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> ocf);
    assert_pin_takes_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> pin == $past(lvl));
    assert_pin_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !match_evt |=> $stable(pin));
    assert_clear_needs_lsb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ocf && !lo_wr) |=> ocf);
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
    import ocmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0] count,
    output logic             cmp_pin,
    output logic             irq
);
    logic [CNT_W-1:0] cmp_val;
    logic lvl, ie, inhibit, lo_wr, match_evt, ocf, stat_rd;

    assign stat_rd = bus_rd && (bus_addr == ADDR_STAT);

    ocmp_regs #(.BW(BUS_W), .CW(CNT_W)) u_regs (
        .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata,
        .cmp_val, .lvl, .ie, .inhibit, .lo_wr
    );

    ocmp_match #(.CW(CNT_W)) u_match (
        .clk, .rst_n, .count, .cmp_val, .inhibit, .match_evt
    );

    ocmp_flag u_flag (
        .clk, .rst_n, .match_evt, .lvl, .stat_rd, .lo_wr, .ocf, .pin(cmp_pin)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata[BIT_LVL] = lvl;
            bus_rdata[BIT_IE]  = ie;
        end else if (bus_addr == ADDR_STAT) begin
            bus_rdata[BIT_FLG] = ocf;
        end else if (bus_addr == ADDR_CMPH) begin
            bus_rdata = cmp_val[CNT_W-1 -: BUS_W];
        end else if (bus_addr == ADDR_CMPH + 8'd1) begin
            bus_rdata = cmp_val[BUS_W-1:0];
        end
    end

    assign irq = ie & ocf;

    assert_irq_follows_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(match_evt) || $rose(ie)));
endmodule

// File: tb/tb_ocmp_unit.sv
module tb_ocmp_unit;
    logic clk = 0;
    logic rst_n = 0;
    logic [7:0] bus_addr = 0, bus_wdata = 0;
    logic bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_rdata;
    logic [15:0] count = 16'h1234;
    logic cmp_pin, irq;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ocmp_unit dut (.*);

    // hi, lo, count, level
    localparam logic [32:0] VEC [0:5] = '{
        {8'h12, 8'h34, 16'h1234, 1'b1},
        {8'h00, 8'h00, 16'h0001, 1'b0},
        {8'hFF, 8'hFF, 16'hFFFF, 1'b0},
        {8'hA5, 8'h5A, 16'hA55A, 1'b1},
        {8'h80, 8'h01, 16'h0180, 1'b0},
        {8'h7F, 8'h00, 16'h7F00, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic set_cnt(input logic [15:0] v);
        @(negedge clk); count = v;
        @(negedge clk);
    endtask

    task automatic clear_flag(input logic [7:0] lo);
        logic [7:0] t;
        rd(8'h13, t);
        wr(8'h17, lo);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic exp_pin;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state R2
        chk("R2 pin", 16'(cmp_pin), 0);
        chk("R2 irq", 16'(irq), 0);
        rd(8'h13, r); chk("R2 status", 16'(r), 0);
        rd(8'h12, r); chk("R2 ctrl", 16'(r), 0);

        // R1 register access
        wr(8'h16, 8'hC3); wr(8'h17, 8'h3C);
        rd(8'h16, r); chk("R1 hi", 16'(r), 16'hC3);
        rd(8'h17, r); chk("R1 lo", 16'(r), 16'h3C);
        // R9 control bits
        wr(8'h12, 8'hFF); rd(8'h12, r); chk("R9 ctrl", 16'(r), 16'h41);
        rd(8'h20, r); chk("R9 unmapped", 16'(r), 0);
        wr(8'h12, 8'h00);

        // vector table R3 R6
        exp_pin = 0;
        foreach (VEC[i]) begin
            logic [7:0] h, l; logic [15:0] c; logic lv, m;
            {h, l, c, lv} = VEC[i];
            m = (c == {h, l});
            set_cnt(~c);
            wr(8'h12, {7'b0, lv});
            wr(8'h16, h); wr(8'h17, l);
            clear_flag(l);
            set_cnt(c);
            if (m) exp_pin = lv;
            rd(8'h13, r); chk("R3 vector flag", 16'(r[6]), 16'(m));
            chk("R6 vector pin", 16'(cmp_pin), 16'(exp_pin));
            set_cnt(~c);
            clear_flag(l);
        end

        // R7 interrupt
        wr(8'h16, 8'h40); wr(8'h17, 8'h00);
        wr(8'h12, 8'h41); set_cnt(16'h4000);
        chk("R7 irq on", 16'(irq), 1);
        wr(8'h12, 8'h01);
        chk("R7 irq masked", 16'(irq), 0);
        // R8 lsb write alone does not clear
        wr(8'h17, 8'h00);
        rd(8'h13, r); chk("R8 no clear", 16'(r[6]), 16'h1);
        // R3 clear while count still equal: no new event
        wr(8'h17, 8'h00);
        rd(8'h13, r); chk("R8 cleared", 16'(r[6]), 0);
        set_cnt(16'h4000);
        rd(8'h13, r); chk("R3 no repeat", 16'(r[6]), 0);

        // R4 inhibit with count already at new value
        set_cnt(16'h5566);
        wr(8'h16, 8'h55);
        set_cnt(16'h5566);   // value reads 0x5500: still not equal, and inhibited
        set_cnt(16'h5500);   // equals current register image, but inhibited
        rd(8'h13, r); chk("R4 inhibited", 16'(r[6]), 0);
        set_cnt(16'h5566);
        wr(8'h17, 8'h66);
        @(negedge clk);
        rd(8'h13, r); chk("R4 release match", 16'(r[6]), 16'h1);
        set_cnt(16'h0000); clear_flag(8'h66);

        // R5 lsb-only write keeps comparison active
        set_cnt(16'h5577);
        wr(8'h17, 8'h77);
        @(negedge clk);
        rd(8'h13, r); chk("R5 lsb only", 16'(r[6]), 16'h1);

        // R2 reset keeps compare value
        wr(8'h16, 8'hBE); wr(8'h17, 8'hEF); wr(8'h12, 8'h41);
        set_cnt(16'h0000);
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        rd(8'h16, r); chk("R2 hi kept", 16'(r), 16'hBE);
        rd(8'h17, r); chk("R2 lo kept", 16'(r), 16'hEF);
        rd(8'h12, r); chk("R2 ctrl cleared", 16'(r), 0);
        chk("R2 pin cleared", 16'(cmp_pin), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule